// File: doc/BRIEF.md
# Dual-Pipeline Issue Reservation Tracker

This block sits at the issue point of an in-order core that has two pipelines. One is an arithmetic pipe and the other is a load/store pipe, and each has an execute, a memory and a write stage. In every cycle it is offered at most one candidate instruction. The candidate is described only by its class, two optional source register numbers and an optional destination register number. The block answers in the same cycle, with a grant or a stall.

A grant requires two things. First, none of the stage slots the candidate would occupy in later cycles may already be claimed by an instruction in flight. Second, every source register must be past the result latency of its last producer. Claims are kept in a shift-register window of future cycles. A granted instruction ORs its class pattern into this window, and the window moves forward by one cycle on every clock. Per-register down-counters track result latency. One forwarding case shortens the wait: a single-word load feeding the data operand of a single-word store that follows it directly.

There is no state machine. The issue decision is combinational, and the window and counters are the only state. Class codes (`req_class`): 0 plain ALU, 1 ALU with constant shift, 2 ALU with register shift, 3 single-word load, 4 single-word store, 5 double load, 6 double store, 7 three/four-register load, 8 three/four-register store, 9 branch, 10 call, 11–15 unused. Stage occupancy is counted from the cycle after grant, which is occupancy cycle 1.

Top module: `dual_pipe_issue_tracker`

## Requirements
- R1: Classes 0 and 1 occupy ALU execute, ALU memory and ALU write in occupancy cycles 1, 2 and 3. They never conflict with one another when issued every cycle. Their destination may be read by an instruction in the very next cycle (latency 1).
- R2: Class 2 holds ALU execute in occupancy cycles 1 and 2, then ALU memory and ALU write. A candidate that needs ALU execute in the following cycle is stalled for exactly one cycle. Its result latency is 2.
- R3: Classes 3–6 claim ALU execute and LSU execute in cycle 1, LSU memory in cycle 2, and ALU write and LSU write in cycle 3. They do not conflict with an ALU or load/store instruction issued in the next cycle. Loads (3, 5) have latency 2, so a reader in the next cycle stalls. Stores (4, 6) create no result even when `dst_valid` is set.
- R4: A class-4 store whose data register (`src_b`) was written by a class-3 load issued in the previous cycle is granted. This bypass does not apply when the register is the store address (`src_a`), and it does not apply when the producer was a class-5 load.
- R5: Classes 7 and 8 claim ALU-E and LSU-E in cycle 1; ALU-E, LSU-E and LSU-M in cycle 2; ALU-E and LSU-M in cycle 3; and ALU-W and LSU-W in cycle 4. A following ALU request stalls for exactly two cycles. Class 7 has latency 3.
- R6: Branches (9) and unused codes (11–15) claim nothing, produce no result and are always granted when their sources are ready. A call (10) claims nothing, but its destination has latency 32.
- R7: `grant` is never high without `req_valid`. `stall` equals `req_valid` with `grant` low. A stalled or invalid request reserves no slot and sets no counter.
- R8: A source whose valid bit is low is not checked for readiness.
- R9: A synchronous reset clears all slot claims and all latency counters, and `grant` is low while `rst` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | A candidate instruction is offered |
| req_class | input | 4 | Instruction class code |
| src_a_valid | input | 1 | Source A is used |
| src_a | input | IDXW | Source A register (store address) |
| src_b_valid | input | 1 | Source B is used |
| src_b | input | IDXW | Source B register (store data) |
| dst_valid | input | 1 | Instruction names a destination |
| dst | input | IDXW | Destination register |
| grant | output | 1 | Candidate issues this cycle |
| stall | output | 1 | Candidate is held this cycle |

## Verification
`grant` and `stall` are combinational in the current request and the stored state. They are therefore due in the same cycle that the request is presented. A grant changes the window and counters only at the next rising edge, so its effect shows first on the request of the next cycle. The bench applies each request just after a falling edge and reads `grant` and `stall` 1 ns later. Each structural or latency hazard is then probed one request per cycle at the exact cycle offsets, counted from the producer's grant cycle, where a stall must begin and where it must end (for example offsets 31 and 32 for a call).

// File: rtl/issue_rsv_pkg.sv
package issue_rsv_pkg;

    localparam int NRES     = 6;
    localparam int PAT_ROWS = 4;
    localparam int LAT_W    = 6;
    localparam int CLS_W    = 4;

    typedef logic [NRES-1:0] res_vec_t;

    // resource bits
    localparam res_vec_t RS_AE = 6'b000001;
    localparam res_vec_t RS_AM = 6'b000010;
    localparam res_vec_t RS_AW = 6'b000100;
    localparam res_vec_t RS_LE = 6'b001000;
    localparam res_vec_t RS_LM = 6'b010000;
    localparam res_vec_t RS_LW = 6'b100000;

    typedef enum logic [CLS_W-1:0] {
        CLS_ALU       = 4'd0,
        CLS_ALU_SHIMM = 4'd1,
        CLS_ALU_SHREG = 4'd2,
        CLS_LD1       = 4'd3,
        CLS_ST1       = 4'd4,
        CLS_LD2       = 4'd5,
        CLS_ST2       = 4'd6,
        CLS_LD34      = 4'd7,
        CLS_ST34      = 4'd8,
        CLS_BR        = 4'd9,
        CLS_CALL      = 4'd10
    } op_class_e;

    typedef struct packed {
        res_vec_t [PAT_ROWS-1:0] rows;   // rows[k] = slots used in occupancy cycle k+1
        logic [LAT_W-1:0]        lat;
        logic                    makes_result;
        logic                    fwd_to_store; // result may feed store data one cycle early
    } class_info_t;

endpackage

// File: rtl/issue_class_table.sv
module issue_class_table
    import issue_rsv_pkg::*;
(
    input  logic [CLS_W-1:0] cls,
    output class_info_t      info
);

    always_comb begin
        info = '0;
        case (cls)
            CLS_ALU, CLS_ALU_SHIMM: begin
                info.rows[0]      = RS_AE;
                info.rows[1]      = RS_AM;
                info.rows[2]      = RS_AW;
                info.lat          = LAT_W'(1);
                info.makes_result = 1'b1;
            end
            CLS_ALU_SHREG: begin
                info.rows[0]      = RS_AE;
                info.rows[1]      = RS_AE;
                info.rows[2]      = RS_AM;
                info.rows[3]      = RS_AW;
                info.lat          = LAT_W'(2);
                info.makes_result = 1'b1;
            end
            CLS_LD1, CLS_LD2: begin
                info.rows[0]      = RS_AE | RS_LE;
                info.rows[1]      = RS_LM;
                info.rows[2]      = RS_AW | RS_LW;
                info.lat          = LAT_W'(2);
                info.makes_result = 1'b1;
                info.fwd_to_store = (cls == CLS_LD1);
            end
            CLS_ST1, CLS_ST2: begin
                info.rows[0]      = RS_AE | RS_LE;
                info.rows[1]      = RS_LM;
                info.rows[2]      = RS_AW | RS_LW;
            end
            CLS_LD34: begin
                info.rows[0]      = RS_AE | RS_LE;
                info.rows[1]      = RS_AE | RS_LE | RS_LM;
                info.rows[2]      = RS_AE | RS_LM;
                info.rows[3]      = RS_AW | RS_LW;
                info.lat          = LAT_W'(3);
                info.makes_result = 1'b1;
            end
            CLS_ST34: begin
                info.rows[0]      = RS_AE | RS_LE;
                info.rows[1]      = RS_AE | RS_LE | RS_LM;
                info.rows[2]      = RS_AE | RS_LM;
                info.rows[3]      = RS_AW | RS_LW;
            end
            CLS_CALL: begin
                info.lat          = LAT_W'(32);
                info.makes_result = 1'b1;
            end
            default: info = '0; // branch and unused codes
        endcase
    end

endmodule

// File: rtl/issue_rsv_window.sv
module issue_rsv_window
    import issue_rsv_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic                    clk,
    input  logic                    rst,
    input  res_vec_t [PAT_ROWS-1:0] claim,
    input  logic                    commit,
    output logic                    conflict
);

    // win_q[k] = slots already claimed for occupancy cycle k+1
    res_vec_t [DEPTH-1:0]    win_q;
    res_vec_t [DEPTH-1:0]    win_d;
    logic     [PAT_ROWS-1:0] row_hit;

    for (genvar k = 0; k < PAT_ROWS; k++) begin : g_hit
        assign row_hit[k] = |(claim[k] & win_q[k]);
    end

    assign conflict = |row_hit;

    for (genvar k = 0; k < DEPTH; k++) begin : g_shift
        res_vec_t older;
        res_vec_t fresh;
        if (k + 1 < DEPTH) begin : g_old
            assign older = win_q[k+1];
        end else begin : g_end
            assign older = '0;
        end
        if (k + 1 < PAT_ROWS) begin : g_new
            assign fresh = commit ? claim[k+1] : '0;
        end else begin : g_none
            assign fresh = '0;
        end
        assign win_d[k] = older | fresh;
    end

    always_ff @(posedge clk) begin
        if (rst) win_q <= '0;
        else     win_q <= win_d;
    end

endmodule

// File: rtl/issue_operand_ready.sv
module issue_operand_ready
    import issue_rsv_pkg::*;
#(
    parameter int NREGS = 16,
    parameter int IDXW  = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             a_valid,
    input  logic [IDXW-1:0]  a_idx,
    input  logic             b_valid,
    input  logic [IDXW-1:0]  b_idx,
    input  logic             store_consumer,
    input  logic             load_en,
    input  logic [IDXW-1:0]  load_idx,
    input  logic [LAT_W-1:0] load_lat,
    input  logic             load_fwd,
    output logic             srcs_ready
);

    logic [LAT_W-1:0] cnt_q [NREGS];
    logic             fwd_q [NREGS];
    logic [LAT_W-1:0] start_val;
    logic             a_ok;
    logic             b_ok;

    assign start_val = (load_lat == '0) ? '0 : load_lat - LAT_W'(1);

    for (genvar r = 0; r < NREGS; r++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst) begin
                cnt_q[r] <= '0;
                fwd_q[r] <= 1'b0;
            end else if (load_en && load_idx == IDXW'(r)) begin
                cnt_q[r] <= start_val;
                fwd_q[r] <= load_fwd;
            end else if (cnt_q[r] != '0) begin
                cnt_q[r] <= cnt_q[r] - LAT_W'(1);
            end
        end
    end

    assign a_ok = !a_valid || (cnt_q[a_idx] == '0);
    assign b_ok = !b_valid || (cnt_q[b_idx] == '0) ||
                  (store_consumer && fwd_q[b_idx] && cnt_q[b_idx] == LAT_W'(1));
    assign srcs_ready = a_ok && b_ok;

endmodule

// File: rtl/dual_pipe_issue_tracker.sv
module dual_pipe_issue_tracker
    import issue_rsv_pkg::*;
#(
    parameter int NREGS = 16,
    parameter int IDXW  = $clog2(NREGS),
    parameter int DEPTH = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            req_valid,
    input  logic [3:0]      req_class,
    input  logic            src_a_valid,
    input  logic [IDXW-1:0] src_a,
    input  logic            src_b_valid,
    input  logic [IDXW-1:0] src_b,
    input  logic            dst_valid,
    input  logic [IDXW-1:0] dst,
    output logic            grant,
    output logic            stall
);

    class_info_t info;
    logic        slot_conflict;
    logic        srcs_ready;
    logic        is_store1;

    issue_class_table u_table (
        .cls  (req_class),
        .info (info)
    );

    issue_rsv_window #(.DEPTH(DEPTH)) u_window (
        .clk      (clk),
        .rst      (rst),
        .claim    (info.rows),
        .commit   (grant),
        .conflict (slot_conflict)
    );

    assign is_store1 = (req_class == CLS_ST1);

    issue_operand_ready #(.NREGS(NREGS), .IDXW(IDXW)) u_ready (
        .clk            (clk),
        .rst            (rst),
        .a_valid        (src_a_valid),
        .a_idx          (src_a),
        .b_valid        (src_b_valid),
        .b_idx          (src_b),
        .store_consumer (is_store1),
        .load_en        (grant && dst_valid && info.makes_result),
        .load_idx       (dst),
        .load_lat       (info.lat),
        .load_fwd       (info.fwd_to_store),
        .srcs_ready     (srcs_ready)
    );

    always_comb begin
        grant = !rst && req_valid && !slot_conflict && srcs_ready;
        stall = req_valid && !grant;
    end

endmodule

// File: rtl/issue_tracker_checker.sv
module issue_tracker_checker
    import issue_rsv_pkg::*;
#(
    parameter int IDXW = 4
) (
    input logic            clk,
    input logic            rst,
    input logic            req_valid,
    input logic [3:0]      req_class,
    input logic            src_a_valid,
    input logic [IDXW-1:0] src_a,
    input logic            src_b_valid,
    input logic            dst_valid,
    input logic [IDXW-1:0] dst,
    input logic            grant,
    input logic            stall
);

    p_grant_stall_excl_r7: assert property (@(posedge clk) disable iff (rst)
        !(grant && stall));

    p_grant_needs_valid_r7: assert property (@(posedge clk) disable iff (rst)
        grant |-> req_valid);

    p_shreg_blocks_alu_r2: assert property (@(posedge clk) disable iff (rst)
        ($past(grant) && $past(req_class) == CLS_ALU_SHREG &&
         req_valid && req_class == CLS_ALU) |-> !grant);

    p_multi_blocks_alu_r5: assert property (@(posedge clk) disable iff (rst)
        ($past(grant, 2) && $past(req_class, 2) == CLS_LD34 &&
         req_valid && req_class == CLS_ALU) |-> !grant);

    p_load_use_r3: assert property (@(posedge clk) disable iff (rst)
        ($past(grant && dst_valid && (req_class == CLS_LD1 || req_class == CLS_LD2)) &&
         req_valid && src_a_valid && src_a == $past(dst)) |-> !grant);

    p_clear_after_reset_r9: assert property (@(posedge clk) disable iff (rst)
        ($past(rst) && req_valid && req_class == CLS_ALU &&
         !src_a_valid && !src_b_valid) |-> grant);

endmodule

bind dual_pipe_issue_tracker issue_tracker_checker #(.IDXW(IDXW)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .req_valid   (req_valid),
    .req_class   (req_class),
    .src_a_valid (src_a_valid),
    .src_a       (src_a),
    .src_b_valid (src_b_valid),
    .dst_valid   (dst_valid),
    .dst         (dst),
    .grant       (grant),
    .stall       (stall)
);

// File: tb/dual_pipe_issue_tracker_test.sv
module dual_pipe_issue_tracker_test;

    localparam int IDXW = 4;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            req_valid = 1'b0;
    logic [3:0]      req_class = '0;
    logic            src_a_valid = 1'b0;
    logic [IDXW-1:0] src_a = '0;
    logic            src_b_valid = 1'b0;
    logic [IDXW-1:0] src_b = '0;
    logic            dst_valid = 1'b0;
    logic [IDXW-1:0] dst = '0;
    logic            grant;
    logic            stall;

    int tests_run = 0;
    int tests_failed = 0;

    always #10 clk = ~clk;

    dual_pipe_issue_tracker uut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_class(req_class),
        .src_a_valid(src_a_valid), .src_a(src_a),
        .src_b_valid(src_b_valid), .src_b(src_b),
        .dst_valid(dst_valid), .dst(dst),
        .grant(grant), .stall(stall)
    );

    // one cycle: present a request, check grant and stall 1 ns later
    task automatic req(input logic [3:0] c, input logic av, input int a,
                       input logic bv, input int b, input logic dv, input int d,
                       input logic exp_g, input string tag);
        @(negedge clk);
        req_valid = 1'b1; req_class = c;
        src_a_valid = av; src_a = IDXW'(a);
        src_b_valid = bv; src_b = IDXW'(b);
        dst_valid = dv;   dst = IDXW'(d);
        #1;
        tests_run++;
        if (grant !== exp_g || stall !== (req_valid && !exp_g)) begin
            tests_failed++;
            $display("FAIL %s: grant=%b stall=%b expected grant=%b stall=%b",
                     tag, grant, stall, exp_g, !exp_g);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            req_valid = 1'b0; src_a_valid = 1'b0; src_b_valid = 1'b0; dst_valid = 1'b0;
        end
    endtask

    task automatic t_reset;
        @(negedge clk);
        rst = 1'b1; req_valid = 1'b1; req_class = 4'd0;
        #1;
        tests_run++;
        if (grant !== 1'b0) begin
            tests_failed++;
            $display("FAIL R9 grant in reset: grant=%b expected 0", grant);
        end
        @(negedge clk);
        rst = 1'b0; req_valid = 1'b0;
        #1;
        tests_run++;
        if (grant !== 1'b0 || stall !== 1'b0) begin
            tests_failed++;
            $display("FAIL R7 idle outputs: grant=%b stall=%b expected 0 0", grant, stall);
        end
    endtask

    task automatic t_alu;
        req(4'd0, 0, 0, 0, 0, 1, 1, 1, "R1 alu first");
        req(4'd1, 1, 1, 0, 0, 1, 2, 1, "R1 dependent const-shift");
        req(4'd0, 1, 2, 1, 1, 1, 3, 1, "R1 back to back");
        idle(6);
    endtask

    task automatic t_shreg;
        req(4'd2, 0, 0, 0, 0, 1, 4, 1, "R2 shift-reg grant");
        req(4'd0, 0, 0, 0, 0, 0, 0, 0, "R2 alu stalls one cycle");
        req(4'd0, 1, 4, 0, 0, 0, 0, 1, "R2 alu after hold");
        idle(6);
        req(4'd2, 0, 0, 0, 0, 1, 4, 1, "R2 producer");
        req(4'd9, 1, 4, 0, 0, 0, 0, 0, "R2 latency 2 stalls reader");
        req(4'd9, 1, 4, 0, 0, 0, 0, 1, "R2 reader ready");
        idle(6);
    endtask

    task automatic t_loadstore;
        req(4'd3, 0, 0, 0, 0, 1, 3, 1, "R3 load grant");
        req(4'd0, 1, 3, 0, 0, 0, 0, 0, "R3 load-use stall");
        req(4'd0, 1, 3, 0, 0, 0, 0, 1, "R3 load-use resolved");
        idle(6);
        req(4'd5, 0, 0, 0, 0, 1, 5, 1, "R3 double load");
        req(4'd0, 0, 0, 0, 0, 0, 0, 1, "R3 no slot clash next alu");
        req(4'd6, 0, 0, 0, 0, 1, 7, 1, "R3 store with dst");
        req(4'd9, 1, 7, 0, 0, 0, 0, 1, "R3 store makes no result");
        idle(6);
    endtask

    task automatic t_bypass;
        req(4'd3, 0, 0, 0, 0, 1, 4, 1, "R4 single load");
        req(4'd4, 1, 5, 1, 4, 0, 0, 1, "R4 store data bypass");
        idle(6);
        req(4'd3, 0, 0, 0, 0, 1, 4, 1, "R4 single load again");
        req(4'd4, 1, 4, 0, 0, 0, 0, 0, "R4 no bypass for address");
        idle(6);
        req(4'd5, 0, 0, 0, 0, 1, 4, 1, "R4 double load");
        req(4'd4, 1, 5, 1, 4, 0, 0, 0, "R4 no bypass from double load");
        idle(6);
    endtask

    task automatic t_multi;
        req(4'd7, 0, 0, 0, 0, 1, 6, 1, "R5 multi load");
        req(4'd0, 0, 0, 0, 0, 0, 0, 0, "R5 alu stall 1");
        req(4'd0, 0, 0, 0, 0, 0, 0, 0, "R5 alu stall 2");
        req(4'd0, 0, 0, 0, 0, 0, 0, 1, "R5 alu granted");
        idle(6);
        req(4'd8, 0, 0, 0, 0, 0, 0, 1, "R5 multi store");
        req(4'd3, 0, 0, 0, 0, 0, 0, 0, "R5 load stalls behind store");
        idle(6);
        req(4'd7, 0, 0, 0, 0, 1, 6, 1, "R5 producer");
        req(4'd9, 1, 6, 0, 0, 0, 0, 0, "R5 latency cycle 1");
        req(4'd9, 1, 6, 0, 0, 0, 0, 0, "R5 latency cycle 2");
        req(4'd9, 1, 6, 0, 0, 0, 0, 1, "R5 latency met");
        idle(6);
    endtask

    task automatic t_no_reserve;
        req(4'd2, 0, 0, 0, 0, 0, 0, 1, "R7 shift-reg");
        req(4'd7, 0, 0, 0, 0, 1, 8, 0, "R7 multi stalls");
        req(4'd0, 1, 8, 0, 0, 0, 0, 1, "R7 stalled multi left no claim");
        idle(6);
        @(negedge clk);
        req_valid = 1'b0; req_class = 4'd7; dst_valid = 1'b1; dst = IDXW'(9);
        req(4'd0, 1, 9, 0, 0, 0, 0, 1, "R7 invalid request left no claim");
        idle(6);
    endtask

    task automatic t_ignored_src;
        req(4'd3, 0, 0, 0, 0, 1, 10, 1, "R8 load");
        req(4'd0, 0, 10, 0, 10, 0, 0, 1, "R8 unused sources ignored");
        idle(6);
        req(4'd9, 0, 0, 0, 0, 0, 0, 1, "R6 branch");
        req(4'd12, 0, 0, 0, 0, 1, 11, 1, "R6 unused code");
        req(4'd0, 1, 11, 0, 0, 0, 0, 1, "R6 branch and unused claim nothing");
        idle(6);
    endtask

    task automatic t_midreset;
        req(4'd7, 0, 0, 0, 0, 1, 6, 1, "R9 producer before reset");
        @(negedge clk);
        rst = 1'b1; req_valid = 1'b0;
        @(negedge clk);
        rst = 1'b0;
        req(4'd0, 1, 6, 0, 0, 0, 0, 1, "R9 reset cleared window and counter");
        idle(6);
    endtask

    task automatic t_call;
        req(4'd10, 0, 0, 0, 0, 1, 8, 1, "R6 call");
        idle(30);
        req(4'd9, 1, 8, 0, 0, 0, 0, 0, "R6 call latency at 31");
        req(4'd9, 1, 8, 0, 0, 0, 0, 1, "R6 call latency met at 32");
        idle(4);
    endtask

    initial begin
        #(20 * 200000);
        tests_run++;
        tests_failed++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", tests_run, tests_failed);
        $finish;
    end

    initial begin
        t_reset();
        t_alu();
        t_shreg();
        t_loadstore();
        t_bypass();
        t_multi();
        t_no_reserve();
        t_ignored_src();
        t_midreset();
        t_call();
        $display("  [TB] %0d tests run, %0d failed", tests_run, tests_failed);
        $finish;
    end

endmodule